// File: doc/BRIEF.md
# SDRAM Boot and Refresh Sequencer

This block sits on the controller side of a two-bank single-data-rate SDRAM. It drives the command pins: chip select, row strobe, column strobe, write enable, address and bank. After reset it brings the memory up in a fixed order. First it holds a long idle period of no-operation commands. Then it closes every bank with a precharge-all, issues a programmable number of auto-refresh commands, and writes the mode register. All gaps between these commands are counted in clock cycles that parameters set.

Once the memory is up, the block raises `ready` and passes commands from a user port straight to the pins, one cycle after the clock edge that accepts them. A free-running interval counter marks when the next auto-refresh is due. A due refresh wins over any user request. `ready` falls, and the block closes all banks, waits the precharge time and issues the auto-refresh. After the refresh cycle time has passed, `ready` comes back. The interval counter restarts each time the periodic refresh is issued.

Command codes are written as {cs_n, ras_n, cas_n, we_n}: no-operation 0111, precharge 0010, auto-refresh 0001, mode set 0000.

Top module: `sdram_boot_refresh_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the pins carry no-operation (0111), with address and bank zero, and `ready` is low.
- R2: After reset is released, at least INIT_WAIT cycles of no-operation appear on the pins. The first other command is a precharge-all: code 0010 with address bit 10 high.
- R3: The first auto-refresh (0001) follows the precharge-all by exactly T_RP cycles. Further start-up refreshes follow one another at exactly T_RC cycles. Exactly INIT_REFRESHES of them occur before the mode set.
- R4: The mode set (0000) comes exactly T_RC cycles after the last start-up refresh. MODE_KEY sits in address bits KEY_W-1:0, and every higher address bit and the bank are zero.
- R5: `ready` stays low through start-up and rises exactly T_MRD cycles after the mode set appears on the pins.
- R6: When `ready` is high at a clock edge and `user_req` is high, the user command, address and bank appear on the pins after that edge. With `user_req` low, a no-operation with zero address and bank appears instead.
- R7: User inputs have no effect while `ready` is low. The command on the pins in the cycle after a low `ready` is never the one presented by the user.
- R8: Each periodic refresh slot starts with a precharge-all while `ready` is low. The auto-refresh follows exactly T_RP cycles later, and `ready` returns high exactly T_RC cycles after that auto-refresh.
- R9: Consecutive periodic auto-refreshes lie between REFRESH_INTERVAL and REFRESH_INTERVAL + T_RP + 1 cycles apart.
- R10: A due refresh takes priority over user requests. `ready` falls even while `user_req` is held high, and the precharge-all of the slot appears exactly two cycles after `ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_req | input | 1 | User asks to issue its command this cycle |
| user_cmd | input | 4 | User command {cs_n, ras_n, cas_n, we_n} |
| user_addr | input | ADDR_W | User address |
| user_ba | input | BA_W | User bank |
| ready | output | 1 | High when a user request will be accepted at the next edge |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins |
| sd_ba | output | BA_W | Bank select pins |

## Verification
The assertions take for granted that the user port never drives the auto-refresh or mode-set codes. The refresh-spacing property reads every auto-refresh on the pins as one the sequencer issued. They also assume reset is held for at least two clock cycles, so that the past value of `ready` seen after release is the reset value. The stimulus keeps within this: the user commands it sends are only activate, read, write, single-bank precharge (address bit 10 low) and burst stop, and it holds reset for five cycles.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command codes {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  // Address bit that turns a precharge into precharge-all
  localparam int PRE_ALL_BIT = 10;

  typedef enum logic [3:0] {
    ST_BOOT_WAIT = 4'd0,
    ST_PRE_ALL   = 4'd1,
    ST_PRE_WAIT  = 4'd2,
    ST_REFRESH   = 4'd3,
    ST_REF_WAIT  = 4'd4,
    ST_MODE_SET  = 4'd5,
    ST_MODE_WAIT = 4'd6,
    ST_RUN       = 4'd7
  } seq_state_t;

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic reload,
  output logic due,
  output logic due_soon
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] START = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || reload) begin
      cnt <= START;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign due      = en && (cnt == '0);
  assign due_soon = en && (cnt <= CW'(1));
endmodule

// File: rtl/seq_cmd_reg.sv
module seq_cmd_reg
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [BA_W-1:0]   ba_d,
  output logic [3:0]        cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BA_W-1:0]   ba_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
    end
  end
endmodule

// File: rtl/sdram_boot_refresh_seq.sv
module sdram_boot_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W           = 11,
  parameter int BA_W             = 1,
  parameter int KEY_W            = 7,
  parameter logic [KEY_W-1:0] MODE_KEY = 7'h22,
  parameter int INIT_WAIT        = 20000,
  parameter int T_RP             = 3,
  parameter int T_RC             = 10,
  parameter int T_MRD            = 2,
  parameter int INIT_REFRESHES   = 8,
  parameter int REFRESH_INTERVAL = 1560
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              user_req,
  input  logic [3:0]        user_cmd,
  input  logic [ADDR_W-1:0] user_addr,
  input  logic [BA_W-1:0]   user_ba,
  output logic              ready,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba
);
  localparam int DLY_W = $clog2(INIT_WAIT + 1);
  localparam int RC_W  = $clog2(INIT_REFRESHES + 1);

  seq_state_t state, state_n;

  logic             dly_load;
  logic [DLY_W-1:0] dly_val;
  logic             dly_done;
  logic [RC_W-1:0]  boot_refs;
  logic             init_done;
  logic             ref_due;
  logic             ref_due_soon;
  logic             ref_reload;
  logic             ready_q;
  logic             accept;

  logic [3:0]        cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;

  seq_delay_timer #(
    .CNT_W  (DLY_W),
    .RST_VAL(INIT_WAIT - 1)
  ) u_delay (
    .clk     (clk),
    .rst     (rst),
    .load    (dly_load),
    .load_val(dly_val),
    .done    (dly_done)
  );

  seq_refresh_timer #(
    .INTERVAL(REFRESH_INTERVAL)
  ) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .en      (init_done),
    .reload  (ref_reload),
    .due     (ref_due),
    .due_soon(ref_due_soon)
  );

  // Next state and gap timer loads
  always_comb begin
    state_n    = state;
    dly_load   = 1'b0;
    dly_val    = '0;
    ref_reload = 1'b0;
    case (state)
      ST_BOOT_WAIT: if (dly_done) state_n = ST_PRE_ALL;
      ST_PRE_ALL: begin
        dly_load = 1'b1;
        dly_val  = DLY_W'(T_RP - 2);
        state_n  = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (dly_done) state_n = ST_REFRESH;
      ST_REFRESH: begin
        dly_load   = 1'b1;
        dly_val    = DLY_W'(T_RC - 2);
        ref_reload = init_done;
        state_n    = ST_REF_WAIT;
      end
      ST_REF_WAIT: begin
        if (dly_done) begin
          if (init_done)                              state_n = ST_RUN;
          else if (boot_refs == RC_W'(INIT_REFRESHES)) state_n = ST_MODE_SET;
          else                                        state_n = ST_REFRESH;
        end
      end
      ST_MODE_SET: begin
        dly_load = 1'b1;
        dly_val  = DLY_W'(T_MRD - 2);
        state_n  = ST_MODE_WAIT;
      end
      ST_MODE_WAIT: if (dly_done) state_n = ST_RUN;
      ST_RUN:       if (ref_due) state_n = ST_PRE_ALL;
      default:      state_n = ST_BOOT_WAIT;
    endcase
  end

  assign accept = (state == ST_RUN) && ready_q && user_req;

  // Command selection ahead of the pin register
  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    if (accept) begin
      cmd_d  = user_cmd;
      addr_d = user_addr;
      ba_d   = user_ba;
    end else begin
      case (state)
        ST_PRE_ALL: begin
          cmd_d               = CMD_PRE;
          addr_d[PRE_ALL_BIT] = 1'b1;
        end
        ST_REFRESH:  cmd_d = CMD_REF;
        ST_MODE_SET: begin
          cmd_d  = CMD_MRS;
          addr_d = ADDR_W'(MODE_KEY);
        end
        default: cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BOOT_WAIT;
      boot_refs <= '0;
      init_done <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      state <= state_n;
      if (state == ST_REFRESH && !init_done) boot_refs <= boot_refs + 1'b1;
      if (state == ST_MODE_WAIT && dly_done) init_done <= 1'b1;
      ready_q <= (state == ST_RUN) && !ref_due_soon;
    end
  end

  seq_cmd_reg #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
  ) u_pins (
    .clk   (clk),
    .rst   (rst),
    .cmd_d (cmd_d),
    .addr_d(addr_d),
    .ba_d  (ba_d),
    .cmd_q (cmd_q),
    .addr_q(sd_addr),
    .ba_q  (sd_ba)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign ready = ready_q;
endmodule

// File: rtl/sdram_boot_refresh_seq_chk.sv
module sdram_boot_refresh_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int BA_W      = 1,
  parameter int KEY_W     = 7,
  parameter logic [KEY_W-1:0] MODE_KEY = 7'h22,
  parameter int INIT_WAIT = 20000,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              user_req,
  input logic [3:0]        user_cmd,
  input logic [ADDR_W-1:0] user_addr,
  input logic [BA_W-1:0]   user_ba,
  input logic              ready,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba
);
  localparam int BW = $clog2(INIT_WAIT + 1);

  logic [3:0]    pin_cmd;
  logic [BW-1:0] boot_cyc;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) boot_cyc <= '0;
    else if (boot_cyc < BW'(INIT_WAIT)) boot_cyc <= boot_cyc + 1'b1;
  end

  // R2
  boot_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (boot_cyc < BW'(INIT_WAIT)) |-> (pin_cmd == CMD_NOP));

  // R4
  mode_key_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd == CMD_MRS) |-> (sd_addr == ADDR_W'(MODE_KEY) && sd_ba == '0));

  // R6
  user_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ready && user_req) |->
      ({pin_cmd, sd_addr, sd_ba} == $past({user_cmd, user_addr, user_ba})));

  // R7
  user_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ready) |-> (pin_cmd == CMD_NOP || pin_cmd == CMD_PRE ||
                       pin_cmd == CMD_REF || pin_cmd == CMD_MRS));

  // R8
  refresh_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_cmd == CMD_REF) |->
      (($past(pin_cmd, T_RP) == CMD_PRE && $past(sd_addr[PRE_ALL_BIT], T_RP)) ||
       ($past(pin_cmd, T_RC) == CMD_REF)));
endmodule

bind sdram_boot_refresh_seq sdram_boot_refresh_seq_chk #(
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .KEY_W    (KEY_W),
  .MODE_KEY (MODE_KEY),
  .INIT_WAIT(INIT_WAIT),
  .T_RP     (T_RP),
  .T_RC     (T_RC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .user_req (user_req),
  .user_cmd (user_cmd),
  .user_addr(user_addr),
  .user_ba  (user_ba),
  .ready    (ready),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_addr  (sd_addr),
  .sd_ba    (sd_ba)
);

// File: tb/test_sdram_boot_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_boot_refresh_seq;
  import sdram_seq_pkg::*;

  localparam int ADDR_W = 11;
  localparam int BA_W   = 1;
  localparam int KEY_W  = 7;
  localparam logic [KEY_W-1:0] MODE_KEY = 7'h22;
  localparam int INIT_WAIT = 20000;
  localparam int T_RP = 3;
  localparam int T_RC = 10;
  localparam int T_MRD = 2;
  localparam int INIT_REFRESHES = 8;
  localparam int REFRESH_INTERVAL = 1560;
  localparam int WD_LIMIT = 150000;

  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_BST = 4'b0110;

  // {req, cmd, addr, ba} stimulus, then {cmd, addr, ba} expected on the pins
  localparam logic [32:0] VEC [0:7] = '{
    {1'b1, C_ACT,   11'h155, 1'b1, C_ACT,   11'h155, 1'b1},
    {1'b1, C_RD,    11'h023, 1'b0, C_RD,    11'h023, 1'b0},
    {1'b1, C_WR,    11'h4A7, 1'b1, C_WR,    11'h4A7, 1'b1},
    {1'b0, C_ACT,   11'h3C3, 1'b1, CMD_NOP, 11'h000, 1'b0},
    {1'b1, CMD_PRE, 11'h000, 1'b1, CMD_PRE, 11'h000, 1'b1},
    {1'b1, C_BST,   11'h001, 1'b0, C_BST,   11'h001, 1'b0},
    {1'b0, C_RD,    11'h0F0, 1'b0, CMD_NOP, 11'h000, 1'b0},
    {1'b1, C_ACT,   11'h3FF, 1'b0, C_ACT,   11'h3FF, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              user_req = 1'b0;
  logic [3:0]        user_cmd = CMD_NOP;
  logic [ADDR_W-1:0] user_addr = '0;
  logic [BA_W-1:0]   user_ba = '0;
  logic              ready;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ADDR_W-1:0] sd_addr;
  logic [BA_W-1:0]   sd_ba;
  logic [3:0]        pc;

  assign pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always #5 clk = ~clk;

  sdram_boot_refresh_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .KEY_W(KEY_W), .MODE_KEY(MODE_KEY),
    .INIT_WAIT(INIT_WAIT), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .INIT_REFRESHES(INIT_REFRESHES), .REFRESH_INTERVAL(REFRESH_INTERVAL)
  ) i_sdram_boot_refresh_seq (
    .clk(clk), .rst(rst), .user_req(user_req), .user_cmd(user_cmd),
    .user_addr(user_addr), .user_ba(user_ba), .ready(ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      chk(1'b0, "watchdog", wd, WD_LIMIT);
      wrap_up();
    end
  end

  // Pin monitor: checks the order and spacing of sequencer commands
  int cyc, nop_lead, last_t, last_kind, boot_refs, mrs_t, per_refs, last_per_t;
  bit first_seen, ready_seen, prev_ready;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; nop_lead = 0; last_t = 0; last_kind = 0; boot_refs = 0;
      mrs_t = -1; per_refs = 0; last_per_t = 0;
      first_seen = 0; ready_seen = 0; prev_ready = 0;
    end else begin
      cyc++;
      if (!first_seen) begin
        if (pc == CMD_NOP) nop_lead++;
        else begin
          first_seen = 1;
          chk(nop_lead >= INIT_WAIT, "R2 idle lead", nop_lead, INIT_WAIT);
          chk(pc == CMD_PRE && sd_addr[PRE_ALL_BIT], "R2 first command", pc, CMD_PRE);
        end
      end
      if (pc == CMD_PRE && sd_addr[PRE_ALL_BIT]) begin
        if (ready_seen) chk(!ready, "R8 precharge while not ready", ready, 0);
        last_kind = 1; last_t = cyc;
      end
      if (pc == CMD_REF) begin
        if (last_kind == 1) chk(cyc - last_t == T_RP, "R3 precharge to refresh", cyc - last_t, T_RP);
        else chk(last_kind == 2 && cyc - last_t == T_RC, "R3 refresh to refresh", cyc - last_t, T_RC);
        if (!ready_seen) boot_refs++;
        else begin
          if (per_refs > 0)
            chk(cyc - last_per_t >= REFRESH_INTERVAL &&
                cyc - last_per_t <= REFRESH_INTERVAL + T_RP + 1,
                "R9 refresh interval", cyc - last_per_t, REFRESH_INTERVAL);
          per_refs++;
          last_per_t = cyc;
        end
        last_kind = 2; last_t = cyc;
      end
      if (pc == CMD_MRS) begin
        chk(last_kind == 2 && cyc - last_t == T_RC, "R4 refresh to mode set", cyc - last_t, T_RC);
        chk(boot_refs == INIT_REFRESHES, "R3 start-up refresh count", boot_refs, INIT_REFRESHES);
        chk(sd_addr == ADDR_W'(MODE_KEY) && sd_ba == '0, "R4 mode key", int'(sd_addr), int'(MODE_KEY));
        mrs_t = cyc; last_kind = 3; last_t = cyc;
      end
      if (ready && !prev_ready) begin
        if (!ready_seen) begin
          chk(mrs_t >= 0 && cyc - mrs_t == T_MRD, "R5 ready after mode set", cyc - mrs_t, T_MRD);
          ready_seen = 1;
        end else begin
          chk(last_kind == 2 && cyc - last_t == T_RC, "R8 ready after refresh", cyc - last_t, T_RC);
        end
      end
      prev_ready = ready;
    end
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    chk(pc == CMD_NOP && sd_addr == '0 && sd_ba == '0, "R1 pins in reset", pc, CMD_NOP);
    chk(!ready, "R1 ready in reset", ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pc == CMD_NOP && !ready, "R1 first cycle after reset", pc, CMD_NOP);

    // R6: vector table walked once ready is up
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk); while (!ready);
      {user_req, user_cmd, user_addr, user_ba} = VEC[i][32:16];
      @(negedge clk);
      chk({pc, sd_addr, sd_ba} == VEC[i][15:0], "R6 user pass-through",
          int'({pc, sd_addr, sd_ba}), int'(VEC[i][15:0]));
      user_req = 1'b0; user_cmd = CMD_NOP; user_addr = '0; user_ba = '0;
    end

    // R7 / R10: request held high across a refresh slot
    do @(negedge clk); while (!ready);
    user_req = 1'b1; user_cmd = C_ACT; user_addr = 11'h0AA; user_ba = '0;
    begin
      bit pr = 1'b1;
      bit dropped = 1'b0;
      int k = 0;
      int drop_k = 0;
      while (1) begin
        @(negedge clk);
        k++;
        if (!pr) chk(pc != C_ACT, "R7 user ignored while not ready", pc, CMD_NOP);
        if (pr && !ready && !dropped) begin dropped = 1'b1; drop_k = k; end
        if (dropped && pc == CMD_PRE && sd_addr[PRE_ALL_BIT])
          chk(k - drop_k == 2, "R10 precharge after ready falls", k - drop_k, 2);
        if (dropped && ready) break;
        pr = ready;
      end
      @(negedge clk);
      chk(pc == C_ACT && sd_addr == 11'h0AA, "R6 request served after slot", pc, C_ACT);
    end
    user_req = 1'b0; user_cmd = CMD_NOP; user_addr = '0;

    // R9: let several periodic refreshes go by
    while (per_refs < 3) @(negedge clk);

    // R1: reset in mid-run, then a full restart
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(pc == CMD_NOP && sd_addr == '0 && sd_ba == '0, "R1 pins after mid-run reset", pc, CMD_NOP);
    chk(!ready, "R1 ready after mid-run reset", ready, 0);
    rst = 1'b0;
    do @(negedge clk); while (!ready);
    repeat (3) @(negedge clk);
    chk(pc == CMD_NOP, "R6 idle after restart", pc, CMD_NOP);
    wrap_up();
  end
endmodule